// File: doc/BRIEF.md
# Four-Bank Edge-Interrupt GPIO Controller

This block is a memory-mapped general-purpose I/O controller serving four banks of pins, each up to 32 wide. A simple 32-bit register bus with separate write and read strobes reaches every bank. Through the bus, software sets pin direction, drives output data and reads back the synchronized pin levels. It also picks which pins record rising and/or falling transitions, and which recorded transitions raise the single combined interrupt line.

Direction and both edge-enable registers have write-only "set bits" and "clear bits" companions. Software can therefore change single pins without a read-modify-write sequence. The banks sit at uneven base offsets. Every register kind sits at a 12-byte step from its bank base, so three banks interleave within one register group and the fourth sits alone higher up. Pad electrical behaviour, pin multiplexing and glitch filtering belong elsewhere.

Top module: `pinbank_gpio`

## Requirements
- R1: After synchronous reset every register is zero: `pad_oe`, `pad_out` and `irq` are all 0, and each readable register reads 0.
- R2: Bank bases are byte addresses 0x000, 0x004, 0x008 and 0x100 (bank 0..3); bank N's pins map to bits [32N+31:32N] of the pin vectors. A register lies at base + 12*k with k from 0 to 13. Any address that is not word aligned or matches no register is ignored on write and reads as 0.
- R3: Register k=1 (offset 0x0C) is the direction register; a 1 bit means output. It is read/write, and its value drives `pad_oe` for that bank.
- R4: Offsets 0x54 and 0x60 are write-only aliases that set or clear the direction bits given as 1s in the write data. Zero data bits leave direction unchanged, and both aliases read as 0.
- R5: Offsets 0x18 and 0x24 set and clear bits of the bank's output data, which drives `pad_out`. Zero data bits have no effect, and both offsets read as 0.
- R6: Offset 0x00 reads the bank's pin levels after a two-flop synchronizer. A pin change is visible in a read issued two or more cycles later.
- R7: Offsets 0x30 and 0x3C hold the rising and falling edge enables (read/write). Offsets 0x6C/0x78 set/clear rising-enable bits and 0x84/0x90 set/clear falling-enable bits, with zero data bits having no effect.
- R8: An enabled transition of the synchronized pin sets the pin's bit in the edge status register (offset 0x48). This happens on the third rising clock edge after the pin changes. A pin with both enables set records either direction.
- R9: Status bits are sticky. Writing 1 to offset 0x48 clears that bit and writing 0 keeps it. If a new edge and a clearing write hit the same bit in the same cycle, the bit stays set.
- R10: Offset 0x9C is the interrupt mask (1 enables). `irq` is a register that equals, one cycle later, the OR over all banks of status AND mask.
- R11: `rdata` is registered. It updates in the cycle after `rd_en` is sampled, takes the register values from before any write in that same cycle, and holds its value while `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 9 | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| pin_in | input | 128 | Pin levels from the pads, bank 0 in the low bits |
| pad_oe | output | 128 | Per-pin output enable |
| pad_out | output | 128 | Per-pin output data |
| irq | output | 1 | Combined interrupt |

## Verification
On every cycle, the assertions check the following:
- status bits never drop without a clearing write;
- an enabled edge always lands in status, and a clearing write removes every bit it targets unless a new edge hit that bit;
- the direction aliases touch only the bits they name;
- `irq` tracks the pending set one cycle late;
- at most one bank accepts a given write;
- `rdata` holds between reads.

Only the bench scenarios can show whether the irregular address map puts each register at the right place. The same goes for the synchronizer latency, for reads of write-only or unmapped addresses returning zero, and for the outcome when an edge and a clear hit the same bit in the same cycle. The bench shows these by comparing against its own reference model and by directed reads.

// File: rtl/pinbank_pkg.sv
package pinbank_pkg;
  localparam int NUM_BANKS = 4;
  localparam int LAST_REG  = 13;
  localparam int HI_WORD   = 64;  // word index of the lone upper bank base

  // index k = offset / 12 within a bank; the order is the address map
  typedef enum logic [3:0] {
    RG_LEVEL = 4'd0,  RG_DIR  = 4'd1,  RG_OSET = 4'd2,  RG_OCLR = 4'd3,
    RG_RISE  = 4'd4,  RG_FALL = 4'd5,  RG_STAT = 4'd6,  RG_DSET = 4'd7,
    RG_DCLR  = 4'd8,  RG_RSET = 4'd9,  RG_RCLR = 4'd10, RG_FSET = 4'd11,
    RG_FCLR  = 4'd12, RG_MASK = 4'd13
  } reg_sel_e;
endpackage

// File: rtl/pinbank_decode.sv
module pinbank_decode
  import pinbank_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [1:0]        bank,
  output reg_sel_e          sel
);
  int wi, rid;

  always_comb begin
    hit  = 1'b0;
    bank = 2'd0;
    sel  = RG_LEVEL;
    wi   = int'(addr[ADDR_W-1:2]);
    rid  = 0;
    if (addr[1:0] == 2'b00) begin
      if (wi >= HI_WORD) begin
        rid = (wi - HI_WORD) / 3;
        if (((wi - HI_WORD) % 3 == 0) && (rid <= LAST_REG)) begin
          hit  = 1'b1;
          bank = 2'd3;
        end
      end else begin
        rid = wi / 3;
        if (rid <= LAST_REG) begin
          hit  = 1'b1;
          bank = 2'(wi % 3);
        end
      end
      sel = reg_sel_e'(rid[3:0]);
    end
  end
endmodule

// File: rtl/pinbank_bank.sv
module pinbank_bank
  import pinbank_pkg::*;
#(
  parameter int PIN_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  reg_sel_e         sel,
  input  logic [31:0]      wdata,
  input  logic [PIN_W-1:0] pins,
  output logic [PIN_W-1:0] oe,
  output logic [PIN_W-1:0] dout,
  output logic [PIN_W-1:0] pend,
  output logic [31:0]      rword
);
  logic [PIN_W-1:0] wd, s1, s2, prev, rise, fall, stat, mask, hits, wclr;

  assign wd   = wdata[PIN_W-1:0];
  assign hits = (s2 & ~prev & rise) | (~s2 & prev & fall);
  assign wclr = (wr && sel == RG_STAT) ? wd : '0;
  assign pend = stat & mask;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= '0; s2 <= '0; prev <= '0;
      oe <= '0; dout <= '0; rise <= '0; fall <= '0; stat <= '0; mask <= '0;
    end else begin
      s1   <= pins;
      s2   <= s1;
      prev <= s2;
      stat <= (stat & ~wclr) | hits;   // a fresh edge beats the clear
      if (wr) begin
        case (sel)
          RG_DIR:  oe   <= wd;
          RG_DSET: oe   <= oe | wd;
          RG_DCLR: oe   <= oe & ~wd;
          RG_OSET: dout <= dout | wd;
          RG_OCLR: dout <= dout & ~wd;
          RG_RISE: rise <= wd;
          RG_RSET: rise <= rise | wd;
          RG_RCLR: rise <= rise & ~wd;
          RG_FALL: fall <= wd;
          RG_FSET: fall <= fall | wd;
          RG_FCLR: fall <= fall & ~wd;
          RG_MASK: mask <= wd;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (sel)
      RG_LEVEL: rword = 32'(s2);
      RG_DIR:   rword = 32'(oe);
      RG_RISE:  rword = 32'(rise);
      RG_FALL:  rword = 32'(fall);
      RG_STAT:  rword = 32'(stat);
      RG_MASK:  rword = 32'(mask);
      default:  rword = 32'd0;
    endcase
  end

  // R9: status never loses a bit without a clearing write
  p_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    !(wr && sel == RG_STAT) |=> ((stat & $past(stat)) == $past(stat)));
  // R9: a clearing write removes each targeted bit not hit by a new edge
  p_w1c_r9: assert property (@(posedge clk) disable iff (rst)
    (wr && sel == RG_STAT) |=> ((stat & $past(wd) & ~$past(hits)) == '0));
  // R8: every enabled edge is recorded
  p_edge_r8: assert property (@(posedge clk) disable iff (rst)
    (|hits) |=> ((stat & $past(hits)) == $past(hits)));
  // R4: the set alias forces its bits and keeps all others
  p_dset_r4: assert property (@(posedge clk) disable iff (rst)
    (wr && sel == RG_DSET) |=> (oe == ($past(oe) | $past(wd))));
endmodule

// File: rtl/pinbank_gpio.sv
module pinbank_gpio
  import pinbank_pkg::*;
#(
  parameter int PIN_W  = 32,
  parameter int ADDR_W = 9
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic                       rd_en,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [31:0]                wdata,
  output logic [31:0]                rdata,
  input  logic [NUM_BANKS*PIN_W-1:0] pin_in,
  output logic [NUM_BANKS*PIN_W-1:0] pad_oe,
  output logic [NUM_BANKS*PIN_W-1:0] pad_out,
  output logic                       irq
);
  logic                       hit;
  logic [1:0]                 bank;
  reg_sel_e                   sel;
  logic [NUM_BANKS-1:0]       bank_wr;
  logic [31:0]                rwords [NUM_BANKS];
  logic [NUM_BANKS*PIN_W-1:0] pend_all;

  pinbank_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr(addr), .hit(hit), .bank(bank), .sel(sel)
  );

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    assign bank_wr[g] = wr_en && hit && (bank == 2'(g));
    pinbank_bank #(.PIN_W(PIN_W)) u_bank (
      .clk(clk), .rst(rst), .wr(bank_wr[g]), .sel(sel), .wdata(wdata),
      .pins(pin_in[g*PIN_W +: PIN_W]),
      .oe(pad_oe[g*PIN_W +: PIN_W]),
      .dout(pad_out[g*PIN_W +: PIN_W]),
      .pend(pend_all[g*PIN_W +: PIN_W]),
      .rword(rwords[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= 32'd0;
      irq   <= 1'b0;
    end else begin
      irq <= |pend_all;
      if (rd_en) rdata <= hit ? rwords[bank] : 32'd0;
    end
  end

  // R10: irq follows the pending set one cycle later
  p_irq_up_r10: assert property (@(posedge clk) disable iff (rst)
    (|pend_all) |=> irq);
  p_irq_down_r10: assert property (@(posedge clk) disable iff (rst)
    !(|pend_all) |=> !irq);
  // R2: one write reaches at most one bank
  p_one_bank_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(bank_wr));
  // R11: read data holds between reads
  p_rd_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));
endmodule

// File: tb/sim_pinbank_gpio.sv
`timescale 1ns/1ps
module sim_pinbank_gpio;
  logic         clk = 0, rst = 1, wr_en = 0, rd_en = 0;
  logic [8:0]   addr = '0;
  logic [31:0]  wdata = '0, rdata;
  logic [127:0] pin_in = '0, pad_oe, pad_out;
  logic         irq;
  int total = 0, bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pinbank_gpio u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pin_in(pin_in), .pad_oe(pad_oe),
    .pad_out(pad_out), .irq(irq)
  );

  // ---------- reference model ----------
  logic [31:0] m_dir[4], m_out[4], m_rise[4], m_fall[4], m_st[4], m_mask[4];
  logic [31:0] m_s1[4], m_s2[4], m_pv[4];
  logic [31:0] m_rdata;
  logic        m_irq;
  int bases[4] = '{0, 4, 8, 256};

  function automatic bit decode(input int a, output int b, output int r);
    b = 0; r = 0;
    for (int i = 0; i < 4; i++) begin
      int off = a - bases[i];
      if (off >= 0 && off % 12 == 0 && off / 12 <= 13) begin
        b = i; r = off / 12; return 1;
      end
    end
    return 0;
  endfunction

  function automatic logic [31:0] readval(input int b, input int r);
    case (r)
      0: return m_s2[b];
      1: return m_dir[b];
      4: return m_rise[b];
      5: return m_fall[b];
      6: return m_st[b];
      13: return m_mask[b];
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk) begin
    int hb, hr;
    bit h;
    logic [31:0] e[4];
    logic irqn;
    if (rst) begin
      for (int b = 0; b < 4; b++) begin
        m_dir[b] = 0; m_out[b] = 0; m_rise[b] = 0; m_fall[b] = 0;
        m_st[b] = 0; m_mask[b] = 0; m_s1[b] = 0; m_s2[b] = 0; m_pv[b] = 0;
      end
      m_rdata = 0; m_irq = 0;
    end else begin
      h = decode(int'(addr), hb, hr);
      irqn = 0;
      for (int b = 0; b < 4; b++) begin
        e[b] = (m_s2[b] & ~m_pv[b] & m_rise[b]) | (~m_s2[b] & m_pv[b] & m_fall[b]);
        irqn |= |(m_st[b] & m_mask[b]);
      end
      if (rd_en) m_rdata = h ? readval(hb, hr) : 32'd0;
      for (int b = 0; b < 4; b++) begin
        if (wr_en && h && hb == b && hr == 6) m_st[b] = m_st[b] & ~wdata;
        m_st[b] = m_st[b] | e[b];
        m_pv[b] = m_s2[b]; m_s2[b] = m_s1[b]; m_s1[b] = pin_in[b*32 +: 32];
      end
      if (wr_en && h) begin
        case (hr)
          1:  m_dir[hb]  = wdata;
          7:  m_dir[hb]  = m_dir[hb] | wdata;
          8:  m_dir[hb]  = m_dir[hb] & ~wdata;
          2:  m_out[hb]  = m_out[hb] | wdata;
          3:  m_out[hb]  = m_out[hb] & ~wdata;
          4:  m_rise[hb] = wdata;
          9:  m_rise[hb] = m_rise[hb] | wdata;
          10: m_rise[hb] = m_rise[hb] & ~wdata;
          5:  m_fall[hb] = wdata;
          11: m_fall[hb] = m_fall[hb] | wdata;
          12: m_fall[hb] = m_fall[hb] & ~wdata;
          13: m_mask[hb] = wdata;
          default: ;
        endcase
      end
      m_irq = irqn;
    end
  end

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R3 pad_oe", pad_oe, {m_dir[3], m_dir[2], m_dir[1], m_dir[0]});
      chk("R5 pad_out", pad_out, {m_out[3], m_out[2], m_out[1], m_out[0]});
      chk("R10 irq", 128'(irq), 128'(m_irq));
      chk("R11 rdata", 128'(rdata), 128'(m_rdata));
    end
  end

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [8:0] a, output logic [31:0] v);
    @(negedge clk); rd_en = 1; addr = a;
    @(negedge clk); rd_en = 0; v = rdata;
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1
    chk("R1 oe", pad_oe, '0); chk("R1 out", pad_out, '0); chk("R1 irq", 128'(irq), 0);
    rd(9'h00C, v); chk("R1 dir read", 128'(v), 0);
    // R3 bank 2 direction
    wr(9'h014, 32'hA5A5_0000);
    rd(9'h014, v); chk("R3 dir readback", 128'(v), 128'(32'hA5A5_0000));
    chk("R3 oe bank2", 128'(pad_oe[95:64]), 128'(32'hA5A5_0000));
    // R4 bank 3 alias
    wr(9'h154, 32'h0000_00F0);
    wr(9'h160, 32'h0000_0030);
    rd(9'h10C, v); chk("R4 dir alias", 128'(v), 128'(32'hC0));
    rd(9'h154, v); chk("R4 alias reads zero", 128'(v), 0);
    // R5 bank 1 output
    wr(9'h01C, 32'h0000_00FF);
    wr(9'h028, 32'h0000_000F);
    chk("R5 pad_out bank1", 128'(pad_out[63:32]), 128'(32'hF0));
    rd(9'h01C, v); chk("R5 set reads zero", 128'(v), 0);
    // R6 level
    pin_in[31:0] = 32'h1234_5678;
    repeat (3) @(negedge clk);
    rd(9'h000, v); chk("R6 level", 128'(v), 128'(32'h1234_5678));
    // R2 unmapped and misaligned
    rd(9'h0A8, v); chk("R2 unmapped", 128'(v), 0);
    rd(9'h101, v); chk("R2 misaligned", 128'(v), 0);
    wr(9'h0A8, 32'hFFFF_FFFF);
    chk("R2 ignored write", pad_oe, {32'hC0, 32'hA5A5_0000, 32'h0, 32'h0});
    // R7 rising enable via alias on bank 1 pin 5
    wr(9'h070, 32'h20);
    rd(9'h034, v); chk("R7 rise alias", 128'(v), 128'(32'h20));
    // R8 rising edge
    pin_in[37] = 1;
    repeat (4) @(negedge clk);
    rd(9'h04C, v); chk("R8 rise status", 128'(v), 128'(32'h20));
    chk("R10 masked off", 128'(irq), 0);
    // R10 unmask
    wr(9'h0A0, 32'h20);
    @(negedge clk); chk("R10 irq up", 128'(irq), 1);
    // R9 clear
    wr(9'h04C, 32'h0);
    rd(9'h04C, v); chk("R9 zero keeps", 128'(v), 128'(32'h20));
    wr(9'h04C, 32'h20);
    @(negedge clk); chk("R9 irq drops after clear", 128'(irq), 0);
    rd(9'h04C, v); chk("R9 cleared", 128'(v), 0);
    // R8 both edges on bank 3 pin 0
    wr(9'h130, 32'h1);
    wr(9'h184, 32'h1);
    rd(9'h13C, v); chk("R7 fall alias", 128'(v), 128'(32'h1));
    pin_in[96] = 1;
    repeat (4) @(negedge clk);
    rd(9'h148, v); chk("R8 both rise", 128'(v), 128'(32'h1));
    wr(9'h148, 32'h1);
    rd(9'h148, v); chk("R9 clear bank3", 128'(v), 0);
    pin_in[96] = 0;
    repeat (4) @(negedge clk);
    rd(9'h148, v); chk("R8 both fall", 128'(v), 128'(32'h1));
    wr(9'h148, 32'h1);
    // R9 edge and clear in the same cycle
    @(negedge clk); pin_in[96] = 1;
    @(posedge clk); @(posedge clk);
    wr(9'h148, 32'h1);
    rd(9'h148, v); chk("R9 edge beats clear", 128'(v), 128'(32'h1));
    // rising enable clear alias
    wr(9'h178, 32'h1);
    rd(9'h130, v); chk("R7 rise clear alias", 128'(v), 0);
    repeat (5) @(negedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule